// File: doc/BRIEF.md
# Bit-Sliced Logic and Add ALU

This block is a purely combinational arithmetic and logic unit for two equal-width operands. It is assembled from identical one-bit slices, and every slice receives the same decoded operation select. Each slice holds a full adder and a small set of logic gates. A multiplexer in the slice picks which of these drives the slice's result bit. The slices form a ripple chain, so the carry-out of slice i is the carry-in of slice i+1. The carry-in of the lowest slice comes from outside the block.

A four-bit operation code chooses one of five functions: bitwise AND, bitwise OR, complement of the first operand, complement of the second operand, or addition with carry-in. The result is one bit wider than the operands. For addition, that top bit holds the carry out of the highest slice. For every other code it is held at zero. Codes with no function assigned give an all-zero result. A datapath uses the block by feeding it two register-file read ports and writing the result back through a destination select.

Top module: `bitslice_alu`

## Requirements
- R1: Operation code 0 drives result[7:0] with the bitwise AND of opa and opb.
- R2: Operation code 1 drives result[7:0] with the bitwise OR of opa and opb.
- R3: Operation code 2 drives result[7:0] with the bitwise complement of opa.
- R4: Operation code 3 drives result[7:0] with the bitwise complement of opb.
- R5: Operation code 4 drives result[7:0] with the low eight bits of opa + opb + carry_in.
- R6: Under operation code 4, result[8] equals the carry out of the most significant slice. The full nine-bit result therefore equals the unsigned sum opa + opb + carry_in.
- R7: Under operation codes 0 to 3, result[8] is 0.
- R8: Operation codes 5 through 15 drive all nine result bits to 0.
- R9: Under operation codes 0 to 3, carry_in has no effect on any result bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 8 | First operand |
| opb | input | 8 | Second operand |
| carry_in | input | 1 | Carry into the least significant slice |
| op_sel | input | 4 | Operation code, shared by all slices |
| result | output | 9 | Result bits [7:0] plus carry/zero bit [8] |

## Verification
Every pair of operand values is applied under every one of the sixteen operation codes, with carry_in alternating along the sweep. This covers each logic function at every bit position. It also exercises every carry pattern of the ripple chain, from no propagation to a carry that runs through all eight slices into bit 8. Separate pairs of vectors differ only in carry_in under the logic codes, which shows that the carry input reaches the result only during addition. The unassigned codes are swept with the same operands, which separates a correct zero output from a slice that leaks a logic or sum bit.

// File: rtl/bitslice_alu_pkg.sv
// Package: shared widths, operation codes and the one-hot slice select.
// Assumes a 4-bit operation code; codes outside the enum are unassigned.
package bitslice_alu_pkg;

    localparam int unsigned OPND_W = 8;
    localparam int unsigned OPC_W  = 4;

    typedef enum logic [OPC_W-1:0] {
        OPC_AND  = 4'd0,
        OPC_OR   = 4'd1,
        OPC_NOTA = 4'd2,
        OPC_NOTB = 4'd3,
        OPC_ADD  = 4'd4
    } opcode_e;

    // One-hot choice broadcast to every slice; all zero means "output zero".
    typedef struct packed {
        logic pick_and;
        logic pick_or;
        logic pick_nota;
        logic pick_notb;
        logic pick_sum;
    } slice_sel_t;

endpackage

// File: rtl/bitslice_alu_decode.sv
// Module: bitslice_alu_decode
// Turns the operation code into the one-hot select shared by all slices.
// Assumes unassigned codes must select nothing, so slices output zero.
module bitslice_alu_decode
    import bitslice_alu_pkg::*;
#(
    parameter int unsigned CODE_W = OPC_W
) (
    input  logic [CODE_W-1:0] code,
    output slice_sel_t        sel
);

    // Purpose: map each operation code onto exactly one select line.
    always_comb begin
        sel = '0;
        case (code)
            CODE_W'(OPC_AND):  sel.pick_and  = 1'b1;
            CODE_W'(OPC_OR):   sel.pick_or   = 1'b1;
            CODE_W'(OPC_NOTA): sel.pick_nota = 1'b1;
            CODE_W'(OPC_NOTB): sel.pick_notb = 1'b1;
            CODE_W'(OPC_ADD):  sel.pick_sum  = 1'b1;
            default:           sel = '0;
        endcase
    end

endmodule

// File: rtl/bitslice_alu_fadd.sv
// Module: bitslice_alu_fadd
// One-bit full adder: sum and majority carry of three inputs.
// Assumes nothing about the caller; purely combinational.
module bitslice_alu_fadd (
    input  logic x,
    input  logic y,
    input  logic cin,
    output logic sum,
    output logic cout
);

    // Purpose: sum is the parity of the inputs, carry is their majority.
    always_comb begin
        sum  = x ^ y ^ cin;
        cout = (x & y) | (y & cin) | (x & cin);
    end

endmodule

// File: rtl/bitslice_alu_slice.sv
// Module: bitslice_alu_slice
// One ALU bit: logic gates and a full adder, with a one-hot output mux.
// Assumes sel is one-hot or all zero; all zero gives a zero result bit.
module bitslice_alu_slice
    import bitslice_alu_pkg::*;
(
    input  logic       a_bit,
    input  logic       b_bit,
    input  logic       c_in,
    input  slice_sel_t sel,
    output logic       r_bit,
    output logic       c_out
);

    logic sum_bit;

    bitslice_alu_fadd u_fadd (
        .x    (a_bit),
        .y    (b_bit),
        .cin  (c_in),
        .sum  (sum_bit),
        .cout (c_out)
    );

    // Purpose: AND-OR multiplexer that picks the selected candidate bit.
    always_comb begin
        r_bit = (sel.pick_and  & (a_bit & b_bit))
              | (sel.pick_or   & (a_bit | b_bit))
              | (sel.pick_nota & ~a_bit)
              | (sel.pick_notb & ~b_bit)
              | (sel.pick_sum  & sum_bit);
    end

endmodule

// File: rtl/bitslice_alu.sv
// Module: bitslice_alu (top)
// Combinational ALU: WIDTH identical slices in a ripple chain sharing
// one decoded select. The top result bit carries the final carry when adding.
// Assumes callers register inputs/outputs as needed; no state inside.
module bitslice_alu
    import bitslice_alu_pkg::*;
#(
    parameter int unsigned WIDTH  = OPND_W,
    parameter int unsigned CODE_W = OPC_W
) (
    input  logic [WIDTH-1:0]  opa,
    input  logic [WIDTH-1:0]  opb,
    input  logic              carry_in,
    input  logic [CODE_W-1:0] op_sel,
    output logic [WIDTH:0]    result
);

    localparam int unsigned CHAIN_W = WIDTH + 1;

    slice_sel_t         sel;
    logic [CHAIN_W-1:0] chain;
    logic [WIDTH-1:0]   bits;

    bitslice_alu_decode #(.CODE_W(CODE_W)) u_dec (
        .code (op_sel),
        .sel  (sel)
    );

    assign chain[0] = carry_in;

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_slice
            bitslice_alu_slice u_slice (
                .a_bit (opa[i]),
                .b_bit (opb[i]),
                .c_in  (chain[i]),
                .sel   (sel),
                .r_bit (bits[i]),
                .c_out (chain[i+1])
            );
        end
    endgenerate

    // Purpose: assemble the result; the top bit is the carry only for addition.
    always_comb begin
        result = {sel.pick_sum & chain[WIDTH], bits};
    end

endmodule

// File: rtl/bitslice_alu_chk.sv
// Module: bitslice_alu_chk
// Checker bound into bitslice_alu; compares the ports against the
// arithmetic definition of each operation code.
module bitslice_alu_chk #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned CODE_W = 4
) (
    input logic [WIDTH-1:0]  opa,
    input logic [WIDTH-1:0]  opb,
    input logic              carry_in,
    input logic [CODE_W-1:0] op_sel,
    input logic [WIDTH:0]    result
);

    logic [WIDTH:0] wide_sum;

    // Purpose: reference sum formed with a plain adder, not the slice chain.
    always_comb wide_sum = {1'b0, opa} + {1'b0, opb} + {{WIDTH{1'b0}}, carry_in};

    // Purpose: check each code's result against its definition.
    always_comb begin
        if (op_sel == CODE_W'(0))
            a_r1_and: assert (result[WIDTH-1:0] == (opa & opb));
        if (op_sel == CODE_W'(1))
            a_r2_or: assert (result[WIDTH-1:0] == (opa | opb));
        if (op_sel == CODE_W'(2))
            a_r3_nota: assert (result[WIDTH-1:0] == ~opa);
        if (op_sel == CODE_W'(3))
            a_r4_notb: assert (result[WIDTH-1:0] == ~opb);
        if (op_sel == CODE_W'(4))
            a_r5_sum_low: assert (result[WIDTH-1:0] == wide_sum[WIDTH-1:0]);
        if (op_sel == CODE_W'(4))
            a_r6_carry_top: assert (result[WIDTH] == wide_sum[WIDTH]);
        if (op_sel < CODE_W'(4))
            a_r7_logic_top_zero: assert (result[WIDTH] == 1'b0);
        if (op_sel > CODE_W'(4))
            a_r8_unused_zero: assert (result == '0);
    end

endmodule

bind bitslice_alu bitslice_alu_chk #(.WIDTH(WIDTH), .CODE_W(CODE_W)) u_chk (
    .opa      (opa),
    .opb      (opb),
    .carry_in (carry_in),
    .op_sel   (op_sel),
    .result   (result)
);

// File: tb/bitslice_alu_test.sv
`timescale 1ns/1ps
// Bench: exhaustive operand sweep over every operation code, plus
// carry-in independence pairs for the logic codes.
module bitslice_alu_test;

    logic       clk;
    logic       rst_n;
    logic [7:0] opa;
    logic [7:0] opb;
    logic       carry_in;
    logic [3:0] op_sel;
    logic [8:0] result;

    int checks;
    int errors;
    bit done;

    bitslice_alu uut (
        .opa      (opa),
        .opb      (opb),
        .carry_in (carry_in),
        .op_sel   (op_sel),
        .result   (result)
    );

    // Purpose: 50 MHz free-running clock.
    initial clk = 1'b0;
    always #10 clk = ~clk;

    // Purpose: expected result computed arithmetically from the requirements.
    function automatic logic [8:0] model(input logic [3:0] op, input logic [7:0] a,
                                         input logic [7:0] b, input logic ci);
        case (op)
            4'd0:    return {1'b0, a & b};
            4'd1:    return {1'b0, a | b};
            4'd2:    return {1'b0, ~a};
            4'd3:    return {1'b0, ~b};
            4'd4:    return 9'(a) + 9'(b) + 9'(ci);
            default: return 9'd0;
        endcase
    endfunction

    // Purpose: name the requirement that the low or top bits belong to.
    function automatic string tag(input logic [3:0] op, input bit top);
        case (op)
            4'd0:    return top ? "R7" : "R1";
            4'd1:    return top ? "R7" : "R2";
            4'd2:    return top ? "R7" : "R3";
            4'd3:    return top ? "R7" : "R4";
            4'd4:    return top ? "R6" : "R5";
            default: return "R8";
        endcase
    endfunction

    // Purpose: apply one vector, wait for settling, compare.
    task automatic apply_check(input logic [3:0] op, input logic [7:0] a,
                               input logic [7:0] b, input logic ci);
        logic [8:0] exp_v;
        op_sel = op; opa = a; opb = b; carry_in = ci;
        #1;
        exp_v = model(op, a, b, ci);
        checks++;
        if (result !== exp_v) begin
            errors++;
            $display("FAIL %s op=%0d a=%02h b=%02h cin=%0b actual=%03h expected=%03h",
                     tag(op, result[8] !== exp_v[8]), op, a, b, ci, result, exp_v);
        end
        #1;
    endtask

    // Purpose: stimulus sequence and summary.
    initial begin
        checks = 0; errors = 0; done = 0;
        rst_n = 1'b0;
        opa = '0; opb = '0; carry_in = 1'b0; op_sel = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        checks++;
        if (result !== 9'd0) begin
            errors++;
            $display("FAIL R1 reset-state actual=%03h expected=000", result);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R9: carry_in toggled alone under each logic code must not move the result.
        for (int op = 0; op < 4; op++) begin
            logic [8:0] r0;
            op_sel = 4'(op); opa = 8'hA5; opb = 8'h3C; carry_in = 1'b0;
            #1 r0 = result;
            carry_in = 1'b1;
            #1;
            checks++;
            if (result !== r0) begin
                errors++;
                $display("FAIL R9 op=%0d actual=%03h expected=%03h", op, result, r0);
            end
        end

        // R6 corner: carry ripples through every slice into bit 8.
        apply_check(4'd4, 8'hFF, 8'h00, 1'b1);
        apply_check(4'd4, 8'hFF, 8'hFF, 1'b1);
        apply_check(4'd4, 8'h80, 8'h80, 1'b0);

        // R1..R8: every operand pair under every code, carry_in alternating.
        for (int a = 0; a < 256; a++)
            for (int b = 0; b < 256; b++)
                for (int op = 0; op < 16; op++)
                    apply_check(4'(op), 8'(a), 8'(b), 1'((a ^ b ^ op) & 1));

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Purpose: watchdog that ends a hung run as a failure.
    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule